// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side answer to an SMBus alert response poll. A device raises its active-low interrupt line when it needs attention. The controller then reads from the alert response address. Every target with a pending alert acknowledges that read and returns its own 7-bit address. The returned byte carries one status bit in its least significant position. All responders share the open-drain data line, so the responder with the lowest byte value wins by wired-AND arbitration. The winner clears its interrupt. A losing responder keeps its interrupt asserted and waits for the next poll.

The block oversamples SCL and SDA with the system clock through a short synchronizer. It detects START, STOP and SCL edges, and it pulls SDA low through an output-enable pin. It answers only when the latched reporting mode is selected and its own alert is armed. A rising edge on the interrupt-pending input arms the alert. Ordinary register access is handled elsewhere.

Top module: `alr_responder`

## Requirements
- R1: An address byte equal to 8'h19 (7-bit address 7'b0001100 followed by a read bit of 1) is the only byte recognised. Any other byte gets no acknowledge, and SDA stays released until the next START or STOP.
- R2: While `latch_mode` is 0 the block ignores the alert response address. It gives no acknowledge, never asserts `sda_oe`, and leaves `int_n` unchanged.
- R3: The block responds only while its alert is armed (`int_n` low). With no armed alert, the alert response address gets no acknowledge.
- R4: When R1 to R3 allow a response, the block pulls SDA low (`sda_oe`=1) during the ninth SCL pulse of the address byte.
- R5: After its acknowledge, the block transmits {`dev_addr`, `flag_high`} MSB first, so `flag_high` is bit 0. It changes `sda_oe` only while SCL is low.
- R6: When the block leaves SDA released for a bit but samples SDA low at the SCL rise, it has lost arbitration. It then releases SDA for the rest of the transfer, and `int_n` stays low.
- R7: When the block sends all eight bits without loss, `int_n` goes high once the ninth SCL pulse of the returned byte rises.
- R8: A rising edge on `irq_pending` drives `int_n` low on the next clock. `int_n` stays low through lost or aborted responses.
- R9: A START or STOP at any point abandons the response and releases SDA. A START begins a fresh address phase. `int_n` is not changed.
- R10: After a synchronous reset, `int_n` is 1, `sda_oe` is 0, and the block waits in idle for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired-AND bus value) |
| dev_addr | input | 7 | This target's own 7-bit address |
| latch_mode | input | 1 | 1 = latched reporting mode, the only mode that answers alert polls |
| flag_high | input | 1 | Status bit returned as the LSB of the response byte |
| irq_pending | input | 1 | Interrupt source; a rising edge arms the alert |
| sda_oe | output | 1 | 1 = pull SDA low |
| int_n | output | 1 | Active-low interrupt output |

## Verification
Every cycle, the in-line assertions check the following. `sda_oe` only rises while the synchronized SCL is low. SDA is driven only in the acknowledge and transmit phases. After a lost bit, the drive stays off. `int_n` rises only after a won transfer, and it falls one clock after `irq_pending` rises.

Only the bench's bus scenarios can show the rest. These cover the byte value a controller actually reads when a competing responder is present, and which responder wins. They also cover the refusal under transparent mode, with no armed alert, or for a wrong address, and the recovery after an abandoned poll.

// File: rtl/alr_pkg.sv
// Package: shared state encoding for the alert responder.
// Assumes: included first in compile order.
package alr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // acknowledging the alert poll
        ST_TX,     // sending the response byte
        ST_REL,    // releasing SDA after the last bit
        ST_CACK,   // controller's acknowledge clock
        ST_HOLD    // passive until START or STOP
    } alr_state_e;
endpackage

// File: rtl/alr_line_monitor.sv
// Module: alr_line_monitor
// Synchronizes SCL and SDA into the clock domain and derives SCL edges
// and START/STOP conditions. Assumes the bus is much slower than clk.
module alr_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_p, sda_p;

    // Synchronizer chains and one-cycle-delayed copies; lines idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[SYNC_STAGES-1];
            sda_p    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/alr_resp_fsm.sv
// Module: alr_resp_fsm
// Recognises the alert poll, acknowledges it, and shifts out
// {address, status bit} MSB first with bitwise arbitration.
// Assumes synchronized inputs from alr_line_monitor.
module alr_resp_fsm
    import alr_pkg::*;
#(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              latch_mode,
    input  logic              alert_act,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              flag_high,
    output logic              sda_oe,
    output logic              win_pulse
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    alr_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q, tx_q;
    logic [BYTE_W-1:0] rx_next;
    logic              ack_on_q;

    // Next value of the receive shifter on an SCL rise.
    always_comb rx_next = {rx_q[BYTE_W-2:0], sda_s};

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            ack_on_q  <= 1'b0;
            sda_oe    <= 1'b0;
            win_pulse <= 1'b0;
        end else begin
            win_pulse <= 1'b0;
            if (start_det) begin
                state_q  <= ST_ADDR;
                cnt_q    <= '0;
                ack_on_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                ack_on_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        rx_q <= rx_next;
                        if (cnt_q == LAST) begin
                            if (rx_next == {ARA_ADDR, 1'b1} && latch_mode && alert_act) begin
                                state_q <= ST_ACK;
                                tx_q    <= {dev_addr, flag_high};
                            end else begin
                                state_q <= ST_HOLD;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_on_q) begin
                            ack_on_q <= 1'b1;
                            sda_oe   <= 1'b1;
                        end else begin
                            ack_on_q <= 1'b0;
                            state_q  <= ST_TX;
                            cnt_q    <= '0;
                            sda_oe   <= ~tx_q[BYTE_W-1];
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            if (!sda_oe && !sda_s) state_q <= ST_HOLD;
                            else if (cnt_q == LAST) state_q <= ST_REL;
                            else cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            sda_oe <= ~tx_q[LAST - cnt_q];
                        end
                    end
                    ST_REL: if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_CACK;
                    end
                    ST_CACK: if (scl_rise) begin
                        win_pulse <= 1'b1;
                        state_q   <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA may only start being pulled while SCL is low (R5).
    assert_oe_rise_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // SDA is only pulled in the acknowledge and transmit phases (R2).
    assert_oe_only_responding_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q == ST_ACK || state_q == ST_TX || state_q == ST_REL));
    // After a lost bit the drive stays off (R6).
    assert_lost_stays_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX && scl_rise && !sda_oe && !sda_s) |=> !sda_oe);
    // A completed win never follows from a passive state (R7).
    assert_win_only_from_cack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_pulse |-> $past(state_q) == ST_CACK);
endmodule

// File: rtl/alr_responder.sv
// Module: alr_responder (top)
// Holds the alert latch behind int_n and joins the line monitor with
// the response sequencer. Assumes an open-drain SDA pad outside.
module alr_responder #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] dev_addr,
    input  logic       latch_mode,
    input  logic       flag_high,
    input  logic       irq_pending,
    output logic       sda_oe,
    output logic       int_n
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic win_pulse, alert_q, irq_q;

    alr_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    alr_resp_fsm #(.ADDR_W(7), .ARA_ADDR(7'h0C)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .latch_mode(latch_mode), .alert_act(alert_q),
        .dev_addr(dev_addr), .flag_high(flag_high),
        .sda_oe(sda_oe), .win_pulse(win_pulse)
    );

    // Alert latch: armed by a rising pending edge, cleared only by a win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= irq_pending;
            if (irq_pending && !irq_q) alert_q <= 1'b1;
            else if (win_pulse)        alert_q <= 1'b0;
        end
    end

    // Active-low interrupt view of the latch.
    always_comb int_n = ~alert_q;

    // Interrupt is released only right after a won transfer (R7).
    assert_int_release_after_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> $past(win_pulse));
    // A pending edge arms the interrupt on the next clock (R8).
    assert_int_armed_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_q) |=> !int_n);
endmodule

// File: tb/alr_responder_test.sv
module alr_responder_test;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, ctrl_sda = 1'b1, comp_oe = 1'b0;
    logic [6:0] dev_addr = 7'h50;
    logic latch_mode = 1'b1, flag_high = 1'b0, irq_pending = 1'b0;
    logic sda_oe, int_n;
    wire  sda_bus = ctrl_sda & ~sda_oe & ~comp_oe;

    int n_chk = 0, n_bad = 0;
    bit exp_alert = 1'b0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    alr_responder uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .dev_addr(dev_addr), .latch_mode(latch_mode), .flag_high(flag_high),
        .irq_pending(irq_pending), .sda_oe(sda_oe), .int_n(int_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic arm();
        irq_pending = 1'b0; hw(3);
        irq_pending = 1'b1; hw(3);
        exp_alert = 1'b1;
    endtask

    task automatic do_start();
        ctrl_sda = 1'b1; hw(H); scl = 1'b1; hw(H);
        ctrl_sda = 1'b0; hw(H); scl = 1'b0; hw(2);
    endtask

    task automatic do_stop();
        ctrl_sda = 1'b0; hw(H); scl = 1'b1; hw(H);
        ctrl_sda = 1'b1; hw(H);
    endtask

    task automatic clock_bit(output logic b);
        hw(H); scl = 1'b1; hw(H); b = sda_bus; scl = 1'b0; hw(2);
    endtask

    // Full alert poll; returns DUT ack, bus ack and the byte read.
    task automatic poll(input logic [7:0] ab, input bit comp_act, input logic [7:0] cb,
                        output bit dut_ack, output bit bus_ack, output logic [7:0] got);
        logic b;
        bit alive;
        oe_seen = 1'b0;
        got = 8'hFF;
        do_start();
        for (int i = 7; i >= 0; i--) begin ctrl_sda = ab[i]; clock_bit(b); end
        ctrl_sda = 1'b1; comp_oe = comp_act;
        hw(H); scl = 1'b1; hw(H);
        dut_ack = sda_oe; bus_ack = !sda_bus;
        scl = 1'b0; hw(2);
        if (bus_ack) begin
            alive = comp_act;
            for (int i = 7; i >= 0; i--) begin
                comp_oe = alive && !cb[i];
                clock_bit(b);
                if (alive && cb[i] && !b) alive = 1'b0;
                got[i] = b;
            end
            comp_oe = 1'b0;
            clock_bit(b);
        end
        comp_oe = 1'b0;
        do_stop();
        hw(4);
    endtask

    // Poll with expected values computed from the requirements.
    task automatic scored_poll(input logic [7:0] ab, input bit comp_en, input logic [7:0] cb);
        bit dut_act, comp_act, win, da, ba;
        logic [7:0] db, exp_got, got;
        string tag;
        dut_act  = (ab == 8'h19) && latch_mode && exp_alert;
        comp_act = comp_en && (ab == 8'h19);
        db       = {dev_addr, flag_high};
        exp_got  = (dut_act && comp_act) ? ((db < cb) ? db : cb) : dut_act ? db : cb;
        win      = dut_act && (!comp_act || db < cb);
        tag = (ab != 8'h19) ? "R1" : !latch_mode ? "R2" : !exp_alert ? "R3" : "R4";
        poll(ab, comp_act, cb, da, ba, got);
        check(tag, da, dut_act);
        if (!dut_act) check({tag, " no drive"}, oe_seen, 0);
        if (dut_act || comp_act) check(win || !comp_act ? "R5 byte" : "R6 byte", got, exp_got);
        if (win) exp_alert = 1'b0;
        check(win ? "R7 int_n" : (dut_act ? "R6 int_n" : "R8 int_n"), int_n, !exp_alert);
    endtask

    initial begin
        hw(3); rst_n = 1'b1; hw(2);
        check("R10 int_n", int_n, 1);
        check("R10 sda_oe", sda_oe, 0);

        arm();
        check("R8 armed", int_n, 0);
        // Single responder wins with flag in LSB.
        dev_addr = 7'h2A; flag_high = 1'b1;
        scored_poll(8'h19, 0, 8'h00);
        // Lose against lower address, then win the retry.
        arm();
        dev_addr = 7'h50; flag_high = 1'b0;
        scored_poll(8'h19, 1, {7'h20, 1'b1});
        scored_poll(8'h19, 0, 8'h00);
        // Transparent mode ignores poll.
        arm(); latch_mode = 1'b0;
        scored_poll(8'h19, 0, 8'h00);
        latch_mode = 1'b1;
        // Wrong address byte.
        scored_poll(8'h18, 0, 8'h00);
        // Abort with STOP mid-address (R9).
        begin
            logic b;
            do_start();
            for (int i = 7; i >= 4; i--) begin ctrl_sda = 8'h19 >> i; clock_bit(b); end
            do_stop(); hw(4);
            check("R9 released", sda_oe, 0);
            check("R9 int_n", int_n, 0);
            // Repeated START mid-address, then full poll via new START.
            do_start();
            for (int i = 7; i >= 5; i--) begin ctrl_sda = 8'h19 >> i; clock_bit(b); end
            ctrl_sda = 1'b1; hw(2);
        end
        scored_poll(8'h19, 0, 8'h00);
        // No armed alert: no response (R3).
        scored_poll(8'h19, 0, 8'h00);

        // Random mix with fixed seed.
        void'($urandom(32'd1234));
        for (int k = 0; k < 40; k++) begin
            logic [6:0] ca;
            logic [7:0] ab;
            dev_addr   = 7'($urandom_range(1, 127));
            flag_high  = 1'($urandom);
            latch_mode = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 1) == 1) arm();
            do ca = 7'($urandom_range(1, 127)); while (ca == dev_addr);
            ab = ($urandom_range(0, 9) < 7) ? 8'h19 : 8'($urandom);
            scored_poll(ab, $urandom_range(0, 1) == 1, {ca, 1'($urandom)});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule